// File: doc/BRIEF.md
# Serial Configuration Register Bank with Deferred Commit

This block is the configuration slave that sits between a three-wire serial write port and the control fields of a frequency synthesizer. A host shifts 32-bit frames in on a data pin. Each frame is framed by a latch-enable strobe that is held low while the bits are clocked in. The block keeps a set of writable control words. It also exposes two status words, which other logic drives, as read-only locations. Read data goes back to the host on a separate output pin during the frame that follows the read request.

Some locations can hold a write back in a shadow copy. Nothing in the live control fields changes until the host writes the master word at location zero. All deferred shadows then land in the same cycle, so a new frequency setting never appears half-applied. Every master write also fires a one-cycle start strobe toward the calibration engine. The serial pins are treated as asynchronous to the system clock and pass through synchronisers before any state changes.

Top module: `serial_cfg_regs`

## Requirements
- R1: A frame is shifted in most significant bit first, one bit per rising edge of `sclk_i` while `le_i` is low. It is acted on when `le_i` rises. Bit 31 is the direction (0 write, 1 read), bits 30:27 are the location and bits 26:0 are the payload.
- R2: If the number of bits shifted since the last `le_i` rise is not exactly 32, the frame is discarded. It changes no register, produces no start strobe and leaves the read-out untouched.
- R3: A write to a location 0..NUM_RW-1 that is not deferred replaces that live word with the full 27-bit payload.
- R4: A write to a location whose bit is set in `DBUF_MASK` (default locations 1, 2 and 3) with payload bit 26 set stores the payload in that location's shadow. The live word does not change.
- R5: A write to location 0 stores its payload in live word 0. In the same cycle it copies every pending shadow into its live word and clears all pending marks.
- R6: Every accepted write to location 0 raises `cal_start_o` for exactly one system clock cycle. No other frame raises it.
- R7: Writes to the status locations NUM_RW..NUM_RW+NUM_RO-1 (10 and 11) and to the unused locations 12..15 change nothing.
- R8: After a read frame, the 27-bit content of the addressed location appears on `sdo_o` during the next frame, most significant bit first. Payload bit 26-k is valid before the (k+1)th rising `sclk_i` edge. Locations 10 and 11 return the matching slice of `status_i`, locations 12..15 return zero, and `sdo_o` is low after any accepted write frame. A read changes no register.
- R9: Payload bit 26 set on a location that does not defer is written straight to the live word, bit 26 included.
- R10: After reset all live words and shadows are zero, no shadow is pending, `sdo_o` is low and `cal_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| le_i | input | 1 | Latch enable, low during shifting, rising edge commits the frame |
| status_i | input | NUM_RO*27 | Read-only status words, location NUM_RW+j in slice j |
| sdo_o | output | 1 | Serial read data |
| live_o | output | NUM_RW*27 | Live control words, location i in slice i |
| cal_start_o | output | 1 | One-cycle calibration start strobe |

## Verification
The bench uses the default build: ten writable words, two status words, deferral on locations 1 to 3, and a two-stage synchroniser. The serial clock runs at one eighth of the system clock. With deferral limited to three locations, one master write can be seen committing a mix of pending and non-pending shadows. The other seven writable locations show that payload bit 26 is passed through unchanged where deferral is off. The two status words and the four unused locations make the read-only and read-as-zero paths reachable with random addresses.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
    localparam int unsigned PAY_W   = 27;
    localparam int unsigned ADR_W   = 4;
    localparam int unsigned FRM_W   = 1 + ADR_W + PAY_W;
    localparam int unsigned CNT_MAX = FRM_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic             is_read;
        logic [ADR_W-1:0] addr;
        logic [PAY_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import serial_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sclk_s,
    input  logic   sdi_s,
    input  logic   le_s,
    output logic   shift_en_o,
    output logic   frm_valid_o,
    output frame_t frm_o
);
    typedef struct packed {
        logic             sclk_prev;
        logic             le_prev;
        logic [FRM_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        frame_t           frm;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic sclk_rise, le_rise;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        sclk_rise  = sclk_s & ~st_q.sclk_prev;
        le_rise    = le_s & ~st_q.le_prev;
        st_d.sclk_prev = sclk_s;
        st_d.le_prev   = le_s;
        if (sclk_rise && !le_s) begin
            st_d.shreg = {st_q.shreg[FRM_W-2:0], sdi_s};
            if (st_q.cnt != CNT_W'(CNT_MAX)) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (le_rise) begin
            st_d.cnt = '0;
            if (st_q.cnt == CNT_W'(FRM_W)) begin
                st_d.valid = 1'b1;
                st_d.frm   = frame_t'(st_q.shreg);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_en_o  = sclk_rise & ~le_s;
    assign frm_valid_o = st_q.valid;
    assign frm_o       = st_q.frm;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_MAX));
    assert_len_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> ($past(st_q.cnt) == CNT_W'(FRM_W)));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import serial_cfg_pkg::*;
#(
    parameter int unsigned          NUM_RW    = 10,
    parameter logic [NUM_RW-1:0]    DBUF_MASK = 10'b00_0000_1110
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid_i,
    input  frame_t                  frm_i,
    output logic [NUM_RW*PAY_W-1:0] live_o,
    output logic                    cal_start_o
);
    typedef struct packed {
        logic [NUM_RW-1:0][PAY_W-1:0] live;
        logic [NUM_RW-1:0][PAY_W-1:0] shadow;
        logic [NUM_RW-1:0]            pend;
        logic                         cal;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  is_write;

    always_comb begin
        bk_d     = bk_q;
        bk_d.cal = 1'b0;
        is_write = frm_valid_i && !frm_i.is_read;
        if (is_write && (frm_i.addr == '0)) begin
            bk_d.live[0] = frm_i.data;
            for (int i = 1; i < NUM_RW; i++) begin
                if (bk_q.pend[i]) bk_d.live[i] = bk_q.shadow[i];
            end
            bk_d.pend = '0;
            bk_d.cal  = 1'b1;
        end else if (is_write) begin
            for (int i = 1; i < NUM_RW; i++) begin
                if (frm_i.addr == ADR_W'(i)) begin
                    if (DBUF_MASK[i] && frm_i.data[PAY_W-1]) begin
                        bk_d.shadow[i] = frm_i.data;
                        bk_d.pend[i]   = 1'b1;
                    end else begin
                        bk_d.live[i] = frm_i.data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign live_o      = bk_q.live;
    assign cal_start_o = bk_q.cal;

    assert_cal_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.cal |=> !bk_q.cal);
    assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.cal |-> (bk_q.pend == '0));
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid_i |=> ($stable(bk_q.live) && $stable(bk_q.pend)));
    assert_ignored_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid_i && (frm_i.addr >= ADR_W'(NUM_RW))) |=>
            ($stable(bk_q.live) && $stable(bk_q.shadow) && !bk_q.cal));
endmodule

// File: rtl/cfg_readout.sv
module cfg_readout
    import serial_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [PAY_W-1:0] load_val_i,
    input  logic             shift_en_i,
    output logic             sdo_o
);
    logic [PAY_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_en_i)       sh_d = load_val_i;
        else if (shift_en_i) sh_d = {sh_q[PAY_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sdo_o = sh_q[PAY_W-1];
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
    import serial_cfg_pkg::*;
#(
    parameter int unsigned       NUM_RW      = 10,
    parameter int unsigned       NUM_RO      = 2,
    parameter logic [NUM_RW-1:0] DBUF_MASK   = 10'b00_0000_1110,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_i,
    input  logic                    sdi_i,
    input  logic                    le_i,
    input  logic [NUM_RO*PAY_W-1:0] status_i,
    output logic                    sdo_o,
    output logic [NUM_RW*PAY_W-1:0] live_o,
    output logic                    cal_start_o
);
    localparam int unsigned NUM_LOC = NUM_RW + NUM_RO;

    logic [2:0]       pins_s;
    logic             shift_en, frm_valid;
    frame_t           frm;
    logic [PAY_W-1:0] rd_word;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, sdi_i, le_i}),
        .sync_o  (pins_s)
    );

    cfg_frame_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (pins_s[2]),
        .sdi_s       (pins_s[1]),
        .le_s        (pins_s[0]),
        .shift_en_o  (shift_en),
        .frm_valid_o (frm_valid),
        .frm_o       (frm)
    );

    cfg_regbank #(.NUM_RW(NUM_RW), .DBUF_MASK(DBUF_MASK)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_valid_i (frm_valid),
        .frm_i       (frm),
        .live_o      (live_o),
        .cal_start_o (cal_start_o)
    );

    always_comb begin
        rd_word = '0;
        if (frm.is_read) begin
            for (int i = 0; i < NUM_LOC; i++) begin
                if (frm.addr == ADR_W'(i)) begin
                    if (i < NUM_RW) rd_word = live_o[i*PAY_W +: PAY_W];
                    else            rd_word = status_i[(i-NUM_RW)*PAY_W +: PAY_W];
                end
            end
        end
    end

    cfg_readout u_rdo (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en_i  (frm_valid),
        .load_val_i (rd_word),
        .shift_en_i (shift_en),
        .sdo_o      (sdo_o)
    );

    assert_write_quiet_sdo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm.is_read) |=> !sdo_o);
    assert_read_keeps_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm.is_read) |=> ($stable(live_o) && !cal_start_o));
endmodule

// File: tb/serial_cfg_regs_bench.sv
module serial_cfg_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NRW        = 10;
    localparam int NRO        = 2;
    localparam int PW         = 27;
    localparam logic [NRW-1:0] MASK = 10'b00_0000_1110;

    logic clk = 0, rst_n = 0, sclk = 0, sdi = 0, le = 1;
    logic [NRO*PW-1:0] status;
    logic sdo, cal_start;
    logic [NRW*PW-1:0] live;

    int total = 0, bad = 0, cal_cnt = 0, exp_cal = 0;
    logic [PW-1:0] exp_live [NRW];
    logic [PW-1:0] exp_shad [NRW];
    logic          exp_pend [NRW];
    logic [PW-1:0] exp_next;
    logic [31:0]   cap;

    serial_cfg_regs u_serial_cfg_regs (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .le_i(le),
        .status_i(status), .sdo_o(sdo), .live_o(live), .cal_start_o(cal_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n && cal_start) cal_cnt <= cal_cnt + 1;

    function automatic logic [31:0] mk(input logic rd, input logic [3:0] a, input logic [PW-1:0] d);
        return {rd, a, d};
    endfunction

    function automatic logic [PW-1:0] exp_read(input logic [3:0] a);
        if (a < NRW) return exp_live[a];
        if (a < NRW + NRO) return status[(a-NRW)*PW +: PW];
        return '0;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        cap = '0;
        le = 0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            sdi = bits[n-1-k];
            repeat (HALF) @(negedge clk);
            if (n - 1 - k < 32) cap[31-k] = sdo;
            sclk = 1;
            repeat (HALF) @(negedge clk);
            sclk = 0;
        end
        repeat (HALF) @(negedge clk);
        le = 1;
        repeat (12) @(negedge clk);
    endtask

    // apply a well-formed frame to the model and the design, check read-out of previous frame
    task automatic frame(input logic [31:0] f, input string tag);
        logic [3:0] a;
        a = f[30:27];
        send({32'd0, f}, 32);
        chk({"R8 sdo ", tag}, cap[31:5], exp_next);
        if (f[31]) begin
            exp_next = exp_read(a);
        end else begin
            exp_next = '0;
            if (a == 0) begin
                exp_live[0] = f[26:0];
                for (int i = 1; i < NRW; i++) if (exp_pend[i]) begin
                    exp_live[i] = exp_shad[i]; exp_pend[i] = 0;
                end
                exp_cal++;
            end else if (a < NRW) begin
                if (MASK[a] && f[26]) begin exp_shad[a] = f[26:0]; exp_pend[a] = 1; end
                else exp_live[a] = f[26:0];
            end
        end
    endtask

    task automatic check_live(input string req);
        for (int i = 0; i < NRW; i++) chk(req, live[i*PW +: PW], exp_live[i]);
        chk({req, " R6 cal count"}, cal_cnt, exp_cal);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        status = {27'h5A5A5A5, 27'h0C0FFEE};
        for (int i = 0; i < NRW; i++) begin exp_live[i] = '0; exp_shad[i] = '0; exp_pend[i] = 0; end
        exp_next = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        // R10 reset state
        check_live("R10 reset");
        chk("R10 sdo", sdo, 0);

        // R1 R3 direct write
        frame(mk(0, 4, 27'h1234567), "w4");
        check_live("R1 R3 direct");
        // R5 R6 master write
        frame(mk(0, 0, 27'h0000ABC), "w0");
        check_live("R5 R6 master");
        // R4 deferred write
        frame(mk(0, 2, 27'h4000077), "w2 deferred");
        check_live("R4 deferred");
        frame(mk(0, 3, 27'h0000055), "w3 direct");
        check_live("R3 direct on buffered loc");
        // R9 bit 26 on non-deferring location
        frame(mk(0, 5, 27'h4000011), "w5");
        check_live("R9 direct bit26");
        // R5 commit
        frame(mk(0, 0, 27'h0000001), "commit");
        check_live("R5 commit");
        chk("R5 loc2 committed", live[2*PW +: PW], 27'h4000077);

        // R2 short and long frames
        send({32'd0, mk(0, 0, 27'h7FFFFFF)} >> 1, 31);
        check_live("R2 short");
        send({31'd0, mk(0, 6, 27'h1111111), 1'b1}, 33);
        check_live("R2 long");

        // R7 writes to status and unused
        frame(mk(0, 10, 27'h2222222), "w10");
        frame(mk(0, 13, 27'h3333333), "w13");
        check_live("R7 ignored");
        // R8 reads
        frame(mk(1, 10, 27'h0), "r10");
        frame(mk(1, 11, 27'h0), "r11");
        frame(mk(1, 4, 27'h0), "r4");
        frame(mk(1, 14, 27'h0), "r14");
        frame(mk(1, 2, 27'h0), "r2");
        frame(mk(0, 15, 27'h0), "flush");
        check_live("R8 read no side effect");

        // random mix
        for (int t = 0; t < 70; t++) begin
            logic [31:0] f;
            f = $urandom;
            if (t == 35) status = {27'h1357911, 27'h2468ACE};
            frame(f, "random");
            check_live("R1 R3 R4 R5 random");
        end
        frame(mk(0, 15, 27'h0), "final");
        check_live("final");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule